// File: doc/BRIEF.md
# Programmable Limited-Range Pixel Clamp

This block sits on a pixel stream of three 12-bit colour components (R, G, B) and forces each component into a legal video range before the pixel leaves the display pipe. A 3-bit format code, qualified by a clamp enable, picks the range. Three codes give a fixed limited range for 8, 10 or 12 bits per component. One code gives a separate programmable floor and ceiling for each component. One code, for 6 bits per component, applies no clamping at all.

The programmable limits are held in registers inside the block. A one-cycle write strobe loads them, and reset sets them to a floor of 0x010 and a ceiling of 0xFEF. Pixels pass through a single register stage. The valid flag is delayed by the same amount, so the block drops into a pipeline as one stage with no handshake.

Top module: `range_clamp_top`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. After reset, `out_valid` is 0 and `out_pix` is 0.
- R2: When `clamp_en` is 0, a valid pixel appears on `out_pix` one cycle later unmodified, whatever the value of `fmt_code`.
- R3: With `clamp_en` = 1 and `fmt_code` = 0 (6 bits per component), pixels pass unmodified.
- R4: With `clamp_en` = 1 and `fmt_code` of 1, 2 or 3 (8, 10 or 12 bits per component), each component is limited to 16..235 scaled to that depth and left-aligned in 12 bits. For every one of these codes that is 0x100..0xEB0.
- R5: With `clamp_en` = 1 and `fmt_code` = 7, component R is limited to its own programmed floor and ceiling, and likewise G and B.
- R6: After reset, the programmed floor of every component is 0x010 and the ceiling is 0xFEF.
- R7: Unused codes 4, 5 and 6 pass pixels unmodified even with `clamp_en` = 1.
- R8: While `in_valid` is 0, `out_pix` keeps its last value and `out_valid` is 0.
- R9: Clamping compares against the ceiling first. A value above the ceiling becomes the ceiling; otherwise a value below the floor becomes the floor; otherwise it is unchanged. When the floor exceeds the ceiling, values above the ceiling therefore yield the ceiling and all others yield the floor.
- R10: `lim_wr` loads `lim_lo`/`lim_hi` at the clock edge. A pixel presented in the same cycle as the strobe still uses the old limits, and pixels from the next cycle on use the new ones.
- R11: All pixel and limit buses pack R in bits [35:24], G in [23:12] and B in [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | input pixel qualifier |
| in_pix | input | 36 | input pixel {R,G,B} |
| clamp_en | input | 1 | 0 = full range, pass through |
| fmt_code | input | 3 | range format selector |
| lim_wr | input | 1 | load strobe for programmable limits |
| lim_lo | input | 36 | programmable floors {R,G,B} |
| lim_hi | input | 36 | programmable ceilings {R,G,B} |
| out_valid | output | 1 | output pixel qualifier |
| out_pix | output | 36 | clamped pixel {R,G,B} |

## Verification
Every pixel result, and the matching `out_valid`, is due one clock after the edge that captures the input. The bench drives each input on a falling edge and compares the output on the next falling edge, so exactly one rising edge lies between stimulus and check. Limit writes update the bench's shadow copy only after the same-cycle pixel's expectation has been formed, which matches the one-edge delay of R10. Idle cycles are checked on the following falling edge for a held `out_pix` and a low `out_valid`.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam logic [2:0] FMT_NOCLAMP6 = 3'd0;
  localparam logic [2:0] FMT_VID8     = 3'd1;
  localparam logic [2:0] FMT_VID10    = 3'd2;
  localparam logic [2:0] FMT_VID12    = 3'd3;
  localparam logic [2:0] FMT_PROG     = 3'd7;

  typedef enum logic [1:0] {
    BND_NONE  = 2'd0,
    BND_FIXED = 2'd1,
    BND_PROG  = 2'd2
  } bound_kind_t;

  // Video black level (16 at 8 bits) scaled to depth and left-aligned to width.
  function automatic int unsigned vid_floor(int unsigned depth, int unsigned width);
    return (32'd16 << (depth - 8)) << (width - depth);
  endfunction

  // Video white level (235 at 8 bits) scaled to depth and left-aligned to width.
  function automatic int unsigned vid_ceil(int unsigned depth, int unsigned width);
    return (32'd235 << (depth - 8)) << (width - depth);
  endfunction

  function automatic bound_kind_t decode_kind(logic en, logic [2:0] code);
    if (!en) return BND_NONE;
    case (code)
      FMT_VID8, FMT_VID10, FMT_VID12: return BND_FIXED;
      FMT_PROG:                       return BND_PROG;
      default:                        return BND_NONE;
    endcase
  endfunction
endpackage

// File: rtl/clamp_limit_regs.sv
module clamp_limit_regs #(
  parameter int unsigned W      = 12,
  parameter int unsigned NCOMP  = 3,
  parameter int unsigned DEF_LO = 16,
  parameter int unsigned DEF_HI = 4079
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [NCOMP*W-1:0] lo_in,
  input  logic [NCOMP*W-1:0] hi_in,
  output logic [NCOMP*W-1:0] lo_q,
  output logic [NCOMP*W-1:0] hi_q
);
  localparam logic [W-1:0] RST_LO = W'(DEF_LO);
  localparam logic [W-1:0] RST_HI = W'(DEF_HI);

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[c*W +: W] <= RST_LO;
        hi_q[c*W +: W] <= RST_HI;
      end else if (wr) begin
        lo_q[c*W +: W] <= lo_in[c*W +: W];
        hi_q[c*W +: W] <= hi_in[c*W +: W];
      end
    end
  end
endmodule

// File: rtl/clamp_bound_sel.sv
module clamp_bound_sel
  import clamp_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         en,
  input  logic [2:0]   code,
  input  logic [W-1:0] prog_lo,
  input  logic [W-1:0] prog_hi,
  output logic         active,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam logic [W-1:0] LO8  = W'(vid_floor(8,  W));
  localparam logic [W-1:0] HI8  = W'(vid_ceil (8,  W));
  localparam logic [W-1:0] LO10 = W'(vid_floor(10, W));
  localparam logic [W-1:0] HI10 = W'(vid_ceil (10, W));
  localparam logic [W-1:0] LO12 = W'(vid_floor(12, W));
  localparam logic [W-1:0] HI12 = W'(vid_ceil (12, W));

  bound_kind_t kind;

  always_comb begin
    kind   = decode_kind(en, code);
    active = (kind != BND_NONE);
    lo     = '0;
    hi     = '1;
    if (kind == BND_PROG) begin
      lo = prog_lo;
      hi = prog_hi;
    end else if (kind == BND_FIXED) begin
      case (code)
        FMT_VID8:  begin lo = LO8;  hi = HI8;  end
        FMT_VID10: begin lo = LO10; hi = HI10; end
        default:   begin lo = LO12; hi = HI12; end
      endcase
    end
  end
endmodule

// File: rtl/clamp_lane.sv
module clamp_lane #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         active,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] dout
);
  logic [W-1:0] limited;

  // Ceiling compare takes priority over the floor compare.
  always_comb begin
    if (!active)        limited = din;
    else if (din > hi)  limited = hi;
    else if (din < lo)  limited = lo;
    else                limited = din;
  end

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= limited;
  end
endmodule

// File: rtl/range_clamp_top.sv
module range_clamp_top #(
  parameter int unsigned W      = 12,
  parameter int unsigned NCOMP  = 3,
  parameter int unsigned DEF_LO = 16,
  parameter int unsigned DEF_HI = 4079
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [NCOMP*W-1:0] in_pix,
  input  logic               clamp_en,
  input  logic [2:0]         fmt_code,
  input  logic               lim_wr,
  input  logic [NCOMP*W-1:0] lim_lo,
  input  logic [NCOMP*W-1:0] lim_hi,
  output logic               out_valid,
  output logic [NCOMP*W-1:0] out_pix
);
  logic [NCOMP*W-1:0] prog_lo;
  logic [NCOMP*W-1:0] prog_hi;

  clamp_limit_regs #(.W(W), .NCOMP(NCOMP), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_limits (
    .clk   (clk),
    .rst   (rst),
    .wr    (lim_wr),
    .lo_in (lim_lo),
    .hi_in (lim_hi),
    .lo_q  (prog_lo),
    .hi_q  (prog_hi)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_lane
    logic         act;
    logic [W-1:0] lo_b;
    logic [W-1:0] hi_b;

    clamp_bound_sel #(.W(W)) u_bound (
      .en      (clamp_en),
      .code    (fmt_code),
      .prog_lo (prog_lo[c*W +: W]),
      .prog_hi (prog_hi[c*W +: W]),
      .active  (act),
      .lo      (lo_b),
      .hi      (hi_b)
    );

    clamp_lane #(.W(W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load   (in_valid),
      .din    (in_pix[c*W +: W]),
      .active (act),
      .lo     (lo_b),
      .hi     (hi_b),
      .dout   (out_pix[c*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/range_clamp_chk.sv
module range_clamp_chk #(
  parameter int unsigned W     = 12,
  parameter int unsigned NCOMP = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [NCOMP*W-1:0] in_pix,
  input logic               clamp_en,
  input logic [2:0]         fmt_code,
  input logic               out_valid,
  input logic [NCOMP*W-1:0] out_pix
);
  localparam logic [W-1:0] VLO = W'(clamp_pkg::vid_floor(8, W));
  localparam logic [W-1:0] VHI = W'(clamp_pkg::vid_ceil(8, W));

  function automatic logic all_in_video(logic [NCOMP*W-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int c = 0; c < NCOMP; c++)
      if (p[c*W +: W] < VLO || p[c*W +: W] > VHI) ok = 1'b0;
    return ok;
  endfunction

  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2
  a_r2_full_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clamp_en) |=> (out_pix == $past(in_pix)));
  // R3
  a_r3_code0_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && clamp_en && fmt_code == 3'd0) |=> (out_pix == $past(in_pix)));
  // R4
  a_r4_fixed_window: assert property (@(posedge clk) disable iff (rst)
    (in_valid && clamp_en && fmt_code >= 3'd1 && fmt_code <= 3'd3) |=> all_in_video(out_pix));
  // R7
  a_r7_unused_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && clamp_en && fmt_code >= 3'd4 && fmt_code <= 3'd6) |=> (out_pix == $past(in_pix)));
  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_pix));
endmodule

bind range_clamp_top range_clamp_chk #(.W(W), .NCOMP(NCOMP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_pix    (in_pix),
  .clamp_en  (clamp_en),
  .fmt_code  (fmt_code),
  .out_valid (out_valid),
  .out_pix   (out_pix)
);

// File: tb/range_clamp_top_tb.sv
`timescale 1ns/1ps
module range_clamp_top_tb;
  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [35:0]   in_pix;
  logic          clamp_en;
  logic [2:0]    fmt_code;
  logic          lim_wr;
  logic [35:0]   lim_lo;
  logic [35:0]   lim_hi;
  logic          out_valid;
  logic [35:0]   out_pix;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [35:0] sh_lo;
  logic [35:0] sh_hi;
  logic [35:0] last_exp;

  always #2.5 clk = ~clk;

  range_clamp_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .clamp_en(clamp_en), .fmt_code(fmt_code), .lim_wr(lim_wr),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic logic [11:0] ref_comp(logic [11:0] v, logic en, logic [2:0] code,
                                           logic [11:0] plo, logic [11:0] phi);
    logic [11:0] lo, hi;
    if (!en) return v;
    case (code)
      3'd1, 3'd2, 3'd3: begin lo = 12'h100; hi = 12'hEB0; end
      3'd7:             begin lo = plo;     hi = phi;     end
      default:          return v;
    endcase
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic [35:0] ref_pix(logic [35:0] p, logic en, logic [2:0] code,
                                          logic [35:0] lo, logic [35:0] hi);
    logic [35:0] r;
    for (int c = 0; c < 3; c++)
      r[c*12 +: 12] = ref_comp(p[c*12 +: 12], en, code, lo[c*12 +: 12], hi[c*12 +: 12]);
    return r;
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one pixel and checks it at the next falling edge.
  task automatic step(string req, logic en, logic [2:0] code, logic [35:0] p,
                      logic wr, logic [35:0] lo, logic [35:0] hi);
    logic [35:0] exp;
    in_valid = 1'b1; in_pix = p; clamp_en = en; fmt_code = code;
    lim_wr = wr; lim_lo = lo; lim_hi = hi;
    exp = ref_pix(p, en, code, sh_lo, sh_hi);
    if (wr) begin sh_lo = lo; sh_hi = hi; end
    @(negedge clk);
    check(req, out_pix, exp);
    check({req, " valid"}, {35'd0, out_valid}, 36'd1);
    last_exp = exp;
    lim_wr = 1'b0;
  endtask

  task automatic idle(string req, logic [35:0] junk);
    in_valid = 1'b0; in_pix = junk; clamp_en = 1'b1; fmt_code = 3'd1; lim_wr = 1'b0;
    @(negedge clk);
    check(req, out_pix, last_exp);
    check({req, " valid"}, {35'd0, out_valid}, 36'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] p;
    void'($urandom(32'd7341));
    rst = 1'b1; in_valid = 0; in_pix = '0; clamp_en = 0; fmt_code = 0;
    lim_wr = 0; lim_lo = '0; lim_hi = '0;
    sh_lo = {3{12'h010}}; sh_hi = {3{12'hFEF}};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {35'd0, out_valid}, 36'd0);
    check("R1 reset data", out_pix, 36'd0);
    last_exp = '0;

    // R6 defaults via code 7; R11 packing R/G/B
    step("R6 defaults", 1, 3'd7, {12'h000, 12'hFFF, 12'h800}, 0, '0, '0);
    check("R6 value", last_exp, {12'h010, 12'hFEF, 12'h800});
    // R4 fixed codes, boundaries
    step("R4 code1", 1, 3'd1, {12'h0FF, 12'h100, 12'hEB1}, 0, '0, '0);
    step("R4 code2", 1, 3'd2, {12'hEB0, 12'h000, 12'hFFF}, 0, '0, '0);
    step("R4 code3", 1, 3'd3, {12'hEB1, 12'h0FF, 12'h7A5}, 0, '0, '0);
    check("R4 value", last_exp, {12'hEB0, 12'h100, 12'h7A5});
    // R2 enable low
    step("R2 bypass", 0, 3'd1, {12'h000, 12'hFFF, 12'h001}, 0, '0, '0);
    step("R2 bypass code7", 0, 3'd7, {12'hFFF, 12'h000, 12'hFFE}, 0, '0, '0);
    // R3 code 0
    step("R3 code0", 1, 3'd0, {12'h000, 12'hFFF, 12'h00F}, 0, '0, '0);
    // R7 codes 4..6
    for (int k = 4; k <= 6; k++)
      step("R7 unused", 1, 3'(k), {12'h001, 12'hFFE, 12'hEFF}, 0, '0, '0);
    // R8 hold on idle
    idle("R8 hold", 36'hABCDEF012);
    idle("R8 hold2", 36'h000000000);
    // R10 write in same cycle uses old limits, then new ones
    step("R10 old limits", 1, 3'd7, {12'h005, 12'hFFA, 12'h300},
         1, {12'h200, 12'h040, 12'h300}, {12'h400, 12'hC00, 12'h310});
    check("R10 old value", last_exp, {12'h010, 12'hFEF, 12'h300});
    // R5 per-component limits
    step("R5 per comp", 1, 3'd7, {12'h100, 12'hD00, 12'h2FF}, 0, '0, '0);
    check("R5 value", last_exp, {12'h200, 12'hC00, 12'h300});
    step("R5 upper", 1, 3'd7, {12'h401, 12'h03F, 12'h311}, 0, '0, '0);
    // R9 floor above ceiling
    step("R9 setup", 0, 3'd0, 36'd0, 1, {3{12'h800}}, {3{12'h400}});
    step("R9 inverted", 1, 3'd7, {12'h401, 12'h400, 12'h100}, 0, '0, '0);
    check("R9 value", last_exp, {12'h400, 12'h800, 12'h800});

    // random mix
    for (int i = 0; i < 3000; i++) begin
      p = {$urandom(), $urandom()} & 36'hFFFFFFFFF;
      if ($urandom_range(0, 7) == 0)
        idle("R8 random idle", p);
      else if ($urandom_range(0, 9) == 0)
        step("R10 random write", $urandom_range(0, 1), 3'($urandom_range(0, 7)), p, 1,
             {$urandom(), $urandom()} & 36'hFFFFFFFFF, {$urandom(), $urandom()} & 36'hFFFFFFFFF);
      else
        step("R5 random", $urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), p, 0, '0, '0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule